// File: doc/BRIEF.md
# Boost Switch PWM with Diode-Interval Current Sample Trigger

This block drives the gate of a boost converter switch with a fixed-frequency PWM. The gate is turned on at the start of every switching period and turned off after the on-time count has elapsed. Once per period it raises a one-clock pulse that starts an ADC conversion. The pulse sits halfway through the part of the period in which the switch is off and the diode conducts. In continuous conduction the diode current ramps linearly there, so a sample taken at that midpoint equals the average inductor current over the period.

A current-loop compensator supplies a period length and a requested on-time in clock counts, and may change both on any clock. The block takes both values only when a period ends. It limits the on-time to a programmable ceiling, and never lets it reach the full period. The diode therefore always conducts for a minimum time and the sample point never falls into switching noise. It also emits a one-clock strobe at the first count of every period. At a 100 MHz clock, a period of 1538 counts gives about 65 kHz, and a ceiling of 90 % of the period gives the usual limit.

Top module: `pwm_midoff_trig`

## Requirements
- R1: While `rst_n` is low on a rising clock edge, `gate`, `adc_trig` and `period_start` are all low during the following cycle and the period counter is cleared. The first period starts with the first rising edge at which `rst_n` is high.
- R2: `period_start` is high for exactly one clock, on count 0 of each period. A period lasts P clocks, where P is the `period_cnt` value taken at the start of that period. A value below 2 is treated as 2.
- R3: `gate` goes high only on count 0 of a period. It stays high for counts 0 to D-1, where D is the limited on-time of that period, and it is low for the rest of the period.
- R4: D is the smallest of `duty_req`, `duty_max` and P-1, with all three read at the start of the period. At least one count per period therefore has the gate low.
- R5: `adc_trig` is high for exactly one clock per period, at count floor((D+P)/2).
- R6: `adc_trig` is never high in a cycle in which `gate` is high.
- R7: `period_cnt`, `duty_req` and `duty_max` are read only at a period boundary. Changes to them during a period do not alter the gate length, the trigger position or the length of that period.
- R8: With D = 0 the gate stays low for the whole period and the trigger falls at count floor(P/2).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| period_cnt | input | 16 | Switching period in clock counts |
| duty_req | input | 16 | Requested on-time in clock counts |
| duty_max | input | 16 | Ceiling applied to the on-time |
| gate | output | 1 | Switch gate drive, high = on |
| adc_trig | output | 1 | One-clock sample request at the middle of the off interval |
| period_start | output | 1 | One-clock strobe on count 0 of each period |

## Verification
The delicate coincidence is the trigger landing on the final count of a period. That is the same cycle in which the timer wraps and takes the next period's length, on-time and trigger position. The bench provokes it by requesting an on-time at or above the period, so that the limit gives D = P-1 and the trigger lands on count P-1. It also changes the inputs on that very cycle, and lets random inputs hit it repeatedly. A cycle-accurate reference model compares all three outputs on every clock. A per-period monitor then confirms one trigger per period, and confirms that the new period carries the values taken at the wrap rather than the stale ones.

// File: rtl/pwm_mt_pkg.sv
// Package: shared defaults and types for the mid-off-interval PWM block.
// Assumes: nothing; it holds only constants and a phase encoding.
package pwm_mt_pkg;

    // Default counter width and shortest legal period in counts
    localparam int DEF_CNT_W   = 16;
    localparam int DEF_PER_MIN = 2;

    // Position of the timer within a switching period
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // not yet running after reset
        PH_ON   = 2'd1,   // switch conducting
        PH_OFF  = 2'd2    // diode conducting
    } pwm_phase_t;

endpackage

// File: rtl/pwm_mt_shaper.sv
// Module: pwm_mt_shaper
// Purpose: turns the raw period/on-time requests into the values used for
//          the next period: period floored at PER_MIN, on-time limited to
//          min(request, ceiling, period-1), trigger at floor((D+P)/2).
// Assumes: PER_MIN >= 2, so period-1 never underflows and the trigger
//          always lands on a count where the gate is low.
module pwm_mt_shaper #(
    parameter int CNT_W   = pwm_mt_pkg::DEF_CNT_W,
    parameter int PER_MIN = pwm_mt_pkg::DEF_PER_MIN
) (
    input  logic [CNT_W-1:0] period_in,
    input  logic [CNT_W-1:0] duty_in,
    input  logic [CNT_W-1:0] duty_cap,
    output logic [CNT_W-1:0] per_ok,
    output logic [CNT_W-1:0] duty_ok,
    output logic [CNT_W-1:0] trig_ok
);

    localparam logic [CNT_W-1:0] PER_FLOOR = CNT_W'(PER_MIN);

    logic [CNT_W-1:0] on_top;
    logic [CNT_W-1:0] cap_eff;
    logic [CNT_W:0]   mid_sum;

    // Floor the period so that at least one on and one off count exist
    always_comb begin
        per_ok = (period_in < PER_FLOOR) ? PER_FLOOR : period_in;
    end

    // Limit the on-time to the ceiling and to one count short of the period
    always_comb begin
        on_top  = per_ok - 1'b1;
        cap_eff = (duty_cap < on_top) ? duty_cap : on_top;
        duty_ok = (duty_in < cap_eff) ? duty_in : cap_eff;
    end

    // Midpoint of the off interval: halfway between D and P, rounded down
    always_comb begin
        mid_sum = {1'b0, duty_ok} + {1'b0, per_ok};
        trig_ok = mid_sum[CNT_W:1];
    end

endmodule

// File: rtl/pwm_mt_timer.sv
// Module: pwm_mt_timer
// Purpose: period counter. It holds the active period, on-time and trigger
//          count, and reloads them only when a period ends (or on the first
//          clock after reset).
// Assumes: the loaded period is >= 2; the reset is synchronous, active low.
module pwm_mt_timer #(
    parameter int CNT_W = pwm_mt_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] per_nx,
    input  logic [CNT_W-1:0] duty_nx,
    input  logic [CNT_W-1:0] trig_nx,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] duty_l,
    output logic [CNT_W-1:0] trig_l,
    output logic             run
);

    logic [CNT_W-1:0] per_l;
    logic             wrap;

    // A period ends on its last count; an idle timer starts at once
    always_comb begin
        wrap = !run || (cnt == (per_l - 1'b1));
    end

    // Count through the period and take new settings only at the wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            per_l  <= '0;
            duty_l <= '0;
            trig_l <= '0;
            run    <= 1'b0;
        end else if (wrap) begin
            cnt    <= '0;
            per_l  <= per_nx;
            duty_l <= duty_nx;
            trig_l <= trig_nx;
            run    <= 1'b1;
        end else begin
            cnt    <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/pwm_mt_decode.sv
// Module: pwm_mt_decode
// Purpose: derives gate, sample trigger and period strobe from the timer
//          state. The outputs are decoded directly from registers.
// Assumes: trig_l lies in [duty_l, period-1], which the shaper ensures.
module pwm_mt_decode #(
    parameter int CNT_W = pwm_mt_pkg::DEF_CNT_W
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty_l,
    input  logic [CNT_W-1:0] trig_l,
    input  logic             run,
    output logic             gate,
    output logic             adc_trig,
    output logic             period_start
);

    import pwm_mt_pkg::*;

    pwm_phase_t phase;

    // Classify the current count as idle, switch-on or diode-on
    always_comb begin
        if (!run)              phase = PH_IDLE;
        else if (cnt < duty_l) phase = PH_ON;
        else                   phase = PH_OFF;
    end

    // Drive the three outputs from the phase and the count
    always_comb begin
        gate         = (phase == PH_ON);
        adc_trig     = (phase == PH_OFF) && (cnt == trig_l);
        period_start = (phase != PH_IDLE) && (cnt == '0);
    end

endmodule

// File: rtl/pwm_midoff_trig.sv
// Module: pwm_midoff_trig (top)
// Purpose: leading-edge PWM for a boost switch, with one ADC trigger per
//          period at the middle of the diode conduction interval.
// Assumes: synchronous active-low reset; inputs are synchronous to clk.
module pwm_midoff_trig #(
    parameter int CNT_W   = pwm_mt_pkg::DEF_CNT_W,
    parameter int PER_MIN = pwm_mt_pkg::DEF_PER_MIN
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [15:0]      period_cnt,
    input  logic [15:0]      duty_req,
    input  logic [15:0]      duty_max,
    output logic             gate,
    output logic             adc_trig,
    output logic             period_start
);

    logic [CNT_W-1:0] per_nx, duty_nx, trig_nx;
    logic [CNT_W-1:0] cnt, duty_l, trig_l;
    logic             run;

    pwm_mt_shaper #(.CNT_W(CNT_W), .PER_MIN(PER_MIN)) i_shaper (
        .period_in (CNT_W'(period_cnt)),
        .duty_in   (CNT_W'(duty_req)),
        .duty_cap  (CNT_W'(duty_max)),
        .per_ok    (per_nx),
        .duty_ok   (duty_nx),
        .trig_ok   (trig_nx)
    );

    pwm_mt_timer #(.CNT_W(CNT_W)) i_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .per_nx  (per_nx),
        .duty_nx (duty_nx),
        .trig_nx (trig_nx),
        .cnt     (cnt),
        .duty_l  (duty_l),
        .trig_l  (trig_l),
        .run     (run)
    );

    pwm_mt_decode #(.CNT_W(CNT_W)) i_decode (
        .cnt          (cnt),
        .duty_l       (duty_l),
        .trig_l       (trig_l),
        .run          (run),
        .gate         (gate),
        .adc_trig     (adc_trig),
        .period_start (period_start)
    );

endmodule

// File: rtl/pwm_midoff_trig_chk.sv
// Module: pwm_midoff_trig_chk
// Purpose: property checker bound to pwm_midoff_trig. It watches only the
//          top-level ports and keeps its own record of the triggers seen in
//          the current period.
// Assumes: the bound instance uses a period of at least 2.
module pwm_midoff_trig_chk (
    input logic clk,
    input logic rst_n,
    input logic gate,
    input logic adc_trig,
    input logic period_start
);

    logic seen_q;    // a trigger occurred earlier in the current period
    logic began_q;   // at least one period has started since reset

    // Track triggers per period and whether a period is in progress
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q  <= 1'b0;
            began_q <= 1'b0;
        end else begin
            if (period_start) seen_q <= adc_trig;
            else              seen_q <= seen_q | adc_trig;
            if (period_start) began_q <= 1'b1;
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> (!gate && !adc_trig && !period_start));

    assert_strobe_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        period_start |=> !period_start);

    assert_gate_rise_at_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> period_start);

    assert_no_second_trig_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (adc_trig && !period_start) |-> !seen_q);

    assert_trig_every_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (period_start && began_q) |-> seen_q);

    assert_trig_in_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        adc_trig |-> !gate);

endmodule

bind pwm_midoff_trig pwm_midoff_trig_chk i_pwm_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate         (gate),
    .adc_trig     (adc_trig),
    .period_start (period_start)
);

// File: tb/test_pwm_midoff_trig.sv
// Bench for pwm_midoff_trig. A behavioural reference model runs in step
// with the design and is compared on every clock. A per-period monitor
// measures gate length, trigger count and trigger position.
module test_pwm_midoff_trig;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] period_cnt = 16'd20;
    logic [15:0] duty_req = 16'd8;
    logic [15:0] duty_max = 16'd18;
    logic        gate, adc_trig, period_start;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string cur_tag = "R3";

    always #2 clk = ~clk;   // 250 MHz

    pwm_midoff_trig i_pwm_midoff_trig (
        .clk(clk), .rst_n(rst_n), .period_cnt(period_cnt),
        .duty_req(duty_req), .duty_max(duty_max),
        .gate(gate), .adc_trig(adc_trig), .period_start(period_start)
    );

    // ---------------- reference model ----------------
    int m_cnt = 0, m_per = 0, m_duty = 0, m_trig = 0;
    bit m_run = 0;

    function automatic int lim_duty(int req, int mx, int per);
        int r;
        r = req;
        if (mx < r) r = mx;
        if (per - 1 < r) r = per - 1;
        return r;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_run = 0;
        end else if (!m_run || m_cnt == m_per - 1) begin
            m_per  = (int'(period_cnt) < 2) ? 2 : int'(period_cnt);
            m_duty = lim_duty(int'(duty_req), int'(duty_max), m_per);
            m_trig = (m_duty + m_per) / 2;
            m_cnt  = 0;
            m_run  = 1;
        end else begin
            m_cnt = m_cnt + 1;
        end
    end

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Cycle-by-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit eg, et, es;
            eg = m_run && (m_cnt < m_duty);
            et = m_run && (m_cnt == m_trig);
            es = m_run && (m_cnt == 0);
            if (!m_run && !rst_n) begin
                check(gate == 1'b0, "R1", gate, 0);
                check(adc_trig == 1'b0, "R1", adc_trig, 0);
                check(period_start == 1'b0, "R1", period_start, 0);
            end else begin
                check(gate == eg, "R3", gate, eg);
                check(adc_trig == et, "R5", adc_trig, et);
                check(period_start == es, "R2", period_start, es);
            end
            check(!(gate && adc_trig), "R6", gate & adc_trig, 0);
        end
    end

    // Per-period measurement against the values latched at the period start
    int pm_per, pm_duty, pm_trig, len, glen, tcount, tpos;
    bit inper = 0;
    always @(negedge clk) begin
        if (!done) begin
            if (!rst_n) begin
                inper = 0;
            end else begin
                if (period_start) begin
                    if (inper) begin
                        check(len == pm_per, "R2", len, pm_per);
                        check(glen == pm_duty, cur_tag, glen, pm_duty);
                        check(tcount == 1, "R5", tcount, 1);
                        check(tpos == pm_trig, cur_tag, tpos, pm_trig);
                    end
                    inper = 1; pm_per = m_per; pm_duty = m_duty; pm_trig = m_trig;
                    len = 0; glen = 0; tcount = 0; tpos = -1;
                end
                if (inper) begin
                    if (gate) glen++;
                    if (adc_trig) begin tcount++; tpos = len; end
                    len++;
                end
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    // Stimulus
    initial begin
        cur_tag = "R1";
        idle(5);
        rst_n = 1'b1;
        cur_tag = "R3";
        idle(100);                                   // P=20, D=8, trigger 14
        cur_tag = "R4";
        duty_req = 16'd25;              idle(80);     // ceiling 18 applies
        duty_max = 16'd40; duty_req = 16'd40;        // D = P-1 = 19, trigger on last count
        idle(80);
        duty_req = 16'd40; period_cnt = 16'd12;      // switch period at the wrap
        idle(60);
        cur_tag = "R8";
        duty_req = 16'd0;               idle(60);     // trigger at P/2
        cur_tag = "R2";
        period_cnt = 16'd1; duty_req = 16'd5; idle(20);   // P floored to 2
        period_cnt = 16'd0; idle(10);
        cur_tag = "R4";
        period_cnt = 16'd1538; duty_req = 16'd1500; duty_max = 16'd1384;
        idle(3200);
        cur_tag = "R7";
        for (int i = 0; i < 3000; i++) begin
            period_cnt = 16'($urandom_range(40, 0));
            duty_req   = 16'($urandom_range(45, 0));
            duty_max   = 16'($urandom_range(45, 0));
            @(negedge clk);
        end
        period_cnt = 16'd30; duty_req = 16'd10; duty_max = 16'd27;
        idle(17);
        cur_tag = "R1";
        rst_n = 1'b0;                   idle(3);      // reset mid-period
        rst_n = 1'b1;
        cur_tag = "R3";
        idle(200);
        finish_run();
    end

endmodule